// File: doc/BRIEF.md
# Processor Time-Stamp Counter Unit

This block keeps a free-running count of elapsed time for a processor core. After a synchronous reset the count is zero. From then on it advances under one of two selectable rates. In core-cycle mode it adds one on every core clock edge, so its rate follows whatever frequency the core is running at. In fixed-rate mode it adds the maximum core-to-bus clock ratio once per bus-clock tick strobe, so each unit of the count stands for the same stretch of wall time even when the core frequency changes.

Software obtains the count through a read request. A control bit gates that request: when the bit is set, a registered copy of the count is returned together with a one-cycle valid strobe; when it is clear, the request is refused with a one-cycle fault strobe. A halted core and an asserted stop-clock input both leave the counter running. Only deep sleep freezes it. A constant feature word tells software that the counter is present.

Top module: `tsc_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `count`, `rd_valid` and `rd_fault` become 0 at that edge.
- R2: With `const_mode`=0 (core-cycle mode) and `deep_sleep`=0, `count` grows by exactly 1 at every clock edge.
- R3: `halted` and `stop_clk` have no effect: the count advances just as it does when both are low.
- R4: While `deep_sleep` is 1 at an edge, `count` keeps its value at that edge in both modes, and bus ticks are not accumulated. Once `deep_sleep` is released, counting resumes from the held value.
- R5: With `const_mode`=1 (fixed-rate mode) and `deep_sleep`=0, an edge where `bus_tick` is 1 adds `max_ratio` (zero-extended) to `count`, and an edge where `bus_tick` is 0 leaves `count` unchanged.
- R6: A change of `const_mode` applies from the first edge at which the new value is sampled, and the accumulated count is kept.
- R7: A `rd_req` sampled together with `rd_enable`=1 drives `rd_valid`=1 for the next cycle only, and `rd_data` then equals the `count` visible in the request cycle.
- R8: A `rd_req` sampled together with `rd_enable`=0 drives `rd_fault`=1 and `rd_valid`=0 for the next cycle. `rd_data` keeps its previous value, and `count` advances as if no request had been made.
- R9: `feature_word` has bit 4 set to 1 and all other bits 0.
- R10: `count` wraps modulo 2^CNT_W with no other indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_tick | input | 1 | One-cycle strobe per bus-clock period |
| max_ratio | input | RATIO_W | Maximum core-to-bus clock ratio |
| halted | input | 1 | Core halted indication |
| stop_clk | input | 1 | External stop-clock indication |
| deep_sleep | input | 1 | Deep-sleep indication; freezes the count |
| const_mode | input | 1 | 0 = core-cycle mode, 1 = fixed-rate mode |
| rd_enable | input | 1 | Control bit that permits reads |
| rd_req | input | 1 | Read request |
| count | output | CNT_W | Current counter value |
| rd_data | output | CNT_W | Value captured by the last granted read |
| rd_valid | output | 1 | One-cycle strobe for a granted read |
| rd_fault | output | 1 | One-cycle strobe for a refused read |
| feature_word | output | FEAT_W | Feature word with the presence bit at bit 4 |

## Verification
The wrap past the top of a 64-bit count cannot be reached from reset through the ports in any practical run. The bench therefore runs a second instance with an 8-bit counter on the same stimulus, where a few hundred core-cycle edges cross the boundary, and compares it to the low byte of the reference model. Randomized runs mix deep sleep, ticks, reads and mode flips in the same cycles, so that a read refused during deep sleep, and a mode change in the same edge as a tick, occur besides the directed cases.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
// Package: shared definitions for the time-stamp counter unit.
// Assumes: nothing beyond IEEE 1800-2017.
package tsc_pkg;

    // Increment rate selection.
    typedef enum logic {
        RATE_CORE  = 1'b0,
        RATE_FIXED = 1'b1
    } tsc_rate_e;

    // Bit of the feature word that advertises the counter.
    localparam int FEAT_PRESENT_BIT = 4;

endpackage

// File: rtl/tsc_step_sel.sv
`timescale 1ns/1ps
// tsc_step_sel: picks the amount added to the counter at the next edge
// and whether the counter may advance at all.
// Assumes: bus_tick is a single-cycle strobe in the core clock domain.
module tsc_step_sel
    import tsc_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter int RATIO_W = 8
) (
    input  tsc_rate_e          rate,
    input  logic               bus_tick,
    input  logic [RATIO_W-1:0] max_ratio,
    input  logic               deep_sleep,
    output logic               adv,
    output logic [CNT_W-1:0]   step
);

    logic [CNT_W-1:0] ratio_ext;

    // Fit the ratio to the counter width.
    generate
        if (RATIO_W < CNT_W) begin : g_zext
            assign ratio_ext = {{(CNT_W-RATIO_W){1'b0}}, max_ratio};
        end else begin : g_trunc
            assign ratio_ext = max_ratio[CNT_W-1:0];
        end
    endgenerate

    // Choose step and advance enable from the rate mode.
    always_comb begin
        step = {{(CNT_W-1){1'b0}}, 1'b1};
        adv  = 1'b0;
        if (!deep_sleep) begin
            if (rate == RATE_FIXED) begin
                step = ratio_ext;
                adv  = bus_tick;
            end else begin
                adv  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tsc_accum.sv
`timescale 1ns/1ps
// tsc_accum: the counter register. Adds step when adv is set and wraps
// silently at the top of its range.
// Assumes: synchronous active-low reset.
module tsc_accum #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [CNT_W-1:0] step,
    output logic [CNT_W-1:0] cnt_q
);

    // Accumulate step on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= cnt_q + step;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) !rst_n |=> cnt_q == '0);

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt_q));

    // R10
    modular_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> cnt_q == CNT_W'($past(cnt_q) + $past(step)));

endmodule

// File: rtl/tsc_read_gate.sv
`timescale 1ns/1ps
// tsc_read_gate: grants or refuses read requests according to the enable
// control bit and registers the captured count with a one-cycle strobe.
// Assumes: rd_req is sampled on every edge; no handshake back-pressure.
module tsc_read_gate #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic             rd_enable,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] rd_data,
    output logic             rd_valid,
    output logic             rd_fault
);

    // Produce strobes and capture the count on a granted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            rd_fault <= 1'b0;
        end else begin
            rd_valid <= rd_req && rd_enable;
            rd_fault <= rd_req && !rd_enable;
            if (rd_req && rd_enable)
                rd_data <= cnt_in;
        end
    end

    // R7
    grant_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_enable |=> rd_valid && !rd_fault && rd_data == $past(cnt_in));

    // R8
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_enable |=> rd_fault && !rd_valid && $stable(rd_data));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, rd_fault}));

endmodule

// File: rtl/tsc_unit.sv
`timescale 1ns/1ps
// tsc_unit: time-stamp counter with core-cycle and fixed-rate modes,
// gated reads and a constant feature word.
// Assumes: all inputs are synchronous to clk; halted and stop_clk are
// status only and must not disturb counting.
module tsc_unit
    import tsc_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter int RATIO_W = 8,
    parameter int FEAT_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_tick,
    input  logic [RATIO_W-1:0] max_ratio,
    input  logic               halted,
    input  logic               stop_clk,
    input  logic               deep_sleep,
    input  logic               const_mode,
    input  logic               rd_enable,
    input  logic               rd_req,
    output logic [CNT_W-1:0]   count,
    output logic [CNT_W-1:0]   rd_data,
    output logic               rd_valid,
    output logic               rd_fault,
    output logic [FEAT_W-1:0]  feature_word
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    tsc_rate_e        rate;
    logic             adv;
    logic [CNT_W-1:0] step;

    // Map the mode pin onto the rate type.
    assign rate = tsc_rate_e'(const_mode);

    // Advertise presence of the counter.
    assign feature_word = FEAT_W'(1) << FEAT_PRESENT_BIT;

    tsc_step_sel #(.CNT_W(CNT_W), .RATIO_W(RATIO_W)) u_step (
        .rate      (rate),
        .bus_tick  (bus_tick),
        .max_ratio (max_ratio),
        .deep_sleep(deep_sleep),
        .adv       (adv),
        .step      (step)
    );

    tsc_accum #(.CNT_W(CNT_W)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .step (step),
        .cnt_q(count)
    );

    tsc_read_gate #(.CNT_W(CNT_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .rd_enable(rd_enable),
        .cnt_in   (count),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_fault (rd_fault)
    );

    // R2
    core_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !const_mode && !deep_sleep |=> count == CNT_W'($past(count) + ONE));

    // R3
    halt_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted || stop_clk) && !const_mode && !deep_sleep
        |=> count != $past(count));

    // R4
    sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep |=> $stable(count));

    // R5
    fixed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        const_mode && !bus_tick |=> $stable(count));

    // R5
    fixed_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        const_mode && bus_tick && !deep_sleep
        |=> count == CNT_W'($past(count) + CNT_W'($past(max_ratio))));

endmodule

// File: tb/sim_tsc_unit.sv
`timescale 1ns/1ps
module sim_tsc_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_tick, halted, stop_clk, deep_sleep, const_mode;
    logic        rd_enable, rd_req;
    logic [7:0]  max_ratio;
    logic [63:0] count, rd_data;
    logic        rd_valid, rd_fault;
    logic [31:0] feature_word;
    logic [7:0]  count8, rd_data8;
    logic        rd_valid8, rd_fault8;
    logic [31:0] feature_word8;

    // reference model state
    logic [63:0] m_cnt, m_data;
    logic        m_valid, m_fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    tsc_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .max_ratio(max_ratio),
        .halted(halted), .stop_clk(stop_clk), .deep_sleep(deep_sleep),
        .const_mode(const_mode), .rd_enable(rd_enable), .rd_req(rd_req),
        .count(count), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_fault(rd_fault), .feature_word(feature_word)
    );

    // narrow copy for the wrap boundary
    tsc_unit #(.CNT_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .max_ratio(max_ratio),
        .halted(halted), .stop_clk(stop_clk), .deep_sleep(deep_sleep),
        .const_mode(const_mode), .rd_enable(rd_enable), .rd_req(rd_req),
        .count(count8), .rd_data(rd_data8), .rd_valid(rd_valid8),
        .rd_fault(rd_fault8), .feature_word(feature_word8)
    );

    function automatic logic [63:0] next_cnt(logic [63:0] c, logic rst,
            logic ds, logic cm, logic tk, logic [7:0] mr);
        if (!rst) return 64'd0;
        if (ds) return c;
        if (cm) return tk ? c + {56'd0, mr} : c;
        return c + 64'd1;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // apply current inputs for one edge, update model, compare after
    task automatic step(string req);
        logic [63:0] nd;
        nd = (rst_n && rd_req && rd_enable) ? m_cnt : m_data;
        if (!rst_n) nd = 64'd0;
        m_valid = rst_n && rd_req && rd_enable;
        m_fault = rst_n && rd_req && !rd_enable;
        m_data  = nd;
        m_cnt   = next_cnt(m_cnt, rst_n, deep_sleep, const_mode, bus_tick, max_ratio);
        @(posedge clk);
        @(negedge clk);
        chk(req, count, m_cnt);
        chk(req, {63'd0, rd_valid}, {63'd0, m_valid});
        chk(req, {63'd0, rd_fault}, {63'd0, m_fault});
        chk(req, rd_data, m_data);
        chk({req, "/R10"}, {56'd0, count8}, {56'd0, m_cnt[7:0]});
    endtask

    task automatic idle_inputs();
        bus_tick = 0; halted = 0; stop_clk = 0; deep_sleep = 0;
        const_mode = 0; rd_enable = 1; rd_req = 0; max_ratio = 8'd5;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1d2c3b4a;
        void'($urandom(seed));
        m_cnt = 64'hFFFF; m_data = 64'hFFFF; m_valid = 0; m_fault = 0;
        idle_inputs();
        rst_n = 0;
        @(negedge clk);
        step("R1 reset");
        step("R1 reset");
        chk("R9 feature", {32'd0, feature_word}, 64'h10);
        rst_n = 1;

        // R2 core-cycle counting
        for (int i = 0; i < 5; i++) step("R2 core");
        chk("R2 after five", count, 64'd5);

        // R3 halt and stop-clock keep it running
        halted = 1; step("R3 halted");
        stop_clk = 1; step("R3 both");
        halted = 0; step("R3 stopclk");
        stop_clk = 0;
        chk("R3 total", count, 64'd8);

        // R4 deep sleep freezes, ticks ignored
        deep_sleep = 1; bus_tick = 1;
        for (int i = 0; i < 4; i++) step("R4 sleep");
        const_mode = 1; step("R4 sleep fixed");
        chk("R4 held", count, 64'd8);
        deep_sleep = 0; bus_tick = 0; const_mode = 0;
        step("R4 resume");
        chk("R4 resumed", count, 64'd9);

        // R5 fixed rate: only ticks add max_ratio
        const_mode = 1; max_ratio = 8'd7;
        step("R5 no tick");
        bus_tick = 1; step("R5 tick");
        bus_tick = 0; step("R5 gap");
        max_ratio = 8'd255; bus_tick = 1; step("R5 tick max");
        bus_tick = 0;
        chk("R5 total", count, 64'd9 + 64'd7 + 64'd255);

        // R6 mode flips keep the count
        const_mode = 0; step("R6 to core");
        const_mode = 1; bus_tick = 1; max_ratio = 8'd3; step("R6 to fixed");
        bus_tick = 0;
        chk("R6 total", count, 64'd271 + 64'd1 + 64'd3);

        // R7 granted read, R8 refused read
        rd_enable = 1; rd_req = 1; step("R7 grant");
        chk("R7 data", rd_data, 64'd275);
        rd_req = 0; step("R7 one cycle");
        rd_enable = 0; rd_req = 1; step("R8 refuse");
        chk("R8 data kept", rd_data, 64'd275);
        rd_req = 0; step("R8 one cycle");

        // R10 wrap on narrow instance
        idle_inputs();
        rst_n = 0; step("R1 reset again");
        rst_n = 1;
        for (int i = 0; i < 260; i++) step("R10 wrap");
        chk("R10 narrow", {56'd0, count8}, 64'd4);
        chk("R10 wide", count, 64'd260);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bus_tick   = ($urandom % 3) == 0;
            halted     = $urandom % 2;
            stop_clk   = $urandom % 2;
            deep_sleep = ($urandom % 8) == 0;
            if (($urandom % 40) == 0) const_mode = ~const_mode;
            rd_enable  = $urandom % 2;
            rd_req     = ($urandom % 4) == 0;
            max_ratio  = 8'($urandom);
            rst_n      = ($urandom % 1000) != 0;
            step("R2-R8 random");
        end
        rst_n = 0; step("R1 final reset");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule